// File: doc/BRIEF.md
# Checksummed Register Load Controller

This block controls how device configuration gets loaded from a serial stream of 32-bit words. It loads once after a host reset, and again whenever the frame logic asks for a reload. The host arms it with a falling edge on an active-low reset line. A transfer request is then granted and the stream is accepted. Each word carries an 8-bit register address in its top byte and a 24-bit payload below it. Every transfer ends with a checksum word. Writes are staged while words arrive and reach the register file only when that checksum matches.

Once the first load succeeds, the block reports that display timing may start. After a further fixed delay it reports that the pixel-format outputs are valid. After each completed load, a new programmed transfer is accepted only after the next line-start pulse. A bad checksum stops the transfer, and so does a transfer that runs past its cycle budget. Either fault sends a status code and locks the controller. Only a fresh falling edge on the host reset line frees it.

The controller is a four-state machine:
- ARMED: waits for the first request after a host reset edge. ARMED → LOAD on a request.
- LOAD: accepts words while the grant is high. LOAD → RUN when the checksum matches. LOAD → LOCK when the checksum does not match or the watchdog expires.
- RUN: normal operation. RUN → LOAD on a request, if no transfer has yet completed on the current line.
- LOCK: ignores everything. It is the state after power-up and after any fault.

A host reset edge moves any state to ARMED.

Top module: `reg_load_ctrl`

## Requirements
- R1: After the power-up reset (`arst_n` low) the controller is in LOCK. `xfer_gnt`, `run_ok`, `fmt_valid` and `stat_valid` are 0 and every register reads 0. `xfer_req` is ignored until a host reset edge arrives.
- R2: A host reset edge is a cycle where `host_rst_n` is sampled 0 and was 1 at the previous sample. It moves the controller to ARMED. A request sampled in ARMED raises `xfer_gnt` from the following cycle. `xfer_gnt` stays high until the transfer ends.
- R3: A word with `word_valid` high during the grant and `word_last` low is a data word. Bits 31:24 are the register address and bits 23:0 the payload. Addresses of NREGS (16) or more are dropped. Words offered outside the grant have no effect.
- R4: The word marked `word_last` is compared with the XOR of all 32 bits of every data word in the same transfer. On a match, all staged writes are committed, and a later write to the same address wins. On the next cycle, `stat_valid` pulses with code 2'b11, `xfer_gnt` is 0 and `run_ok` is 1.
- R5: On a mismatch, no register changes. On the next cycle, `stat_valid` pulses with code 2'b10 (shutdown), `run_ok` drops and the controller enters LOCK.
- R6: The grant lasts at most WDOG_CYC (256) cycles. If no checksum word has arrived by the last of them, the controller enters LOCK on the next cycle. It then pulses `stat_valid` with code 2'b01 (overflow), clears `run_ok` and discards the staged writes. Requests are then ignored.
- R7: `fmt_valid` rises exactly FMT_DLY (10) cycles after `run_ok` rises for the first successful load following a host reset edge. Later loads do not delay it. It is never high while `run_ok` is low.
- R8: When a transfer completes, `xfer_req` is ignored until a `line_start` pulse has been sampled. A request sampled on the following cycle is then granted.
- R9: A host reset edge during a transfer ends the grant on the next cycle, with no status pulse. It discards the staged writes, clears `run_ok` and `fmt_valid`, and keeps the committed registers.
- R10: `rd_data` combinationally shows the committed payload at `rd_addr`. Addresses of NREGS or more read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-up reset, active low |
| host_rst_n | input | 1 | Host reset, acts on its falling edge |
| xfer_req | input | 1 | Transfer request |
| xfer_gnt | output | 1 | Transfer granted, words accepted |
| line_start | input | 1 | Start-of-line pulse |
| word_valid | input | 1 | Stream word valid |
| word_data | input | 32 | Stream word: address byte and payload |
| word_last | input | 1 | Marks the checksum word |
| stat_valid | output | 1 | Status code strobe |
| stat_code | output | 2 | 01 overflow, 10 shutdown, 11 load done |
| run_ok | output | 1 | Display timing may run |
| fmt_valid | output | 1 | Pixel-format outputs valid |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 24 | Committed register payload |

## Verification
Assertions check the following on every cycle:
- a status pulse only follows a cycle of LOAD;
- a fault status never coincides with `run_ok`;
- `fmt_valid` implies `run_ok`;
- a grant only rises after a request;
- RUN never re-enters LOAD while the line's transfer is used;
- the watchdog's expiry always ends the grant;
- register contents change only on a commit.

Only the bench's scenarios can show the following:
- the value that wins a duplicate write;
- that out-of-range addresses are dropped;
- the exact 256-cycle boundary;
- the 10-cycle format delay;
- that state survives an abort by host reset.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_LOCK  = 2'd3
    } rlc_state_e;

    localparam logic [1:0] SC_NONE     = 2'b00;
    localparam logic [1:0] SC_OVERFLOW = 2'b01;
    localparam logic [1:0] SC_SHUTDOWN = 2'b10;
    localparam logic [1:0] SC_DONE     = 2'b11;
endpackage

// File: rtl/lc_wdog.sv
module lc_wdog #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic arst_n,
    input  logic active,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = active && (cnt_q == CW'(LIMIT - 1));

    // R6
    wdog_ends_chk: assert property (@(posedge clk) disable iff (!arst_n)
        expire |=> !active);
endmodule

// File: rtl/lc_stage.sv
module lc_stage #(
    parameter int NREGS = 16,
    parameter int AW    = 8,
    parameter int DW    = 24
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             start,
    input  logic             accept,
    input  logic [AW+DW-1:0] word,
    input  logic             commit,
    output logic             csum_ok,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data
);
    localparam int WW = AW + DW;
    localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [WW-1:0] sum_q;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wpay;
    logic [DW-1:0] regs_w [NREGS];

    assign waddr = word[WW-1 -: AW];
    assign wpay  = word[DW-1:0];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            sum_q <= '0;
        end else if (start) begin
            sum_q <= '0;
        end else if (accept) begin
            sum_q <= sum_q ^ word;
        end
    end

    assign csum_ok = (sum_q == word);

    generate
        for (genvar i = 0; i < NREGS; i++) begin : g_ent
            logic [DW-1:0] stg_q;
            logic [DW-1:0] reg_q;
            logic          pnd_q;

            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    stg_q <= '0;
                    pnd_q <= 1'b0;
                    reg_q <= '0;
                end else begin
                    if (start) begin
                        pnd_q <= 1'b0;
                    end else if (accept && (waddr == AW'(i))) begin
                        pnd_q <= 1'b1;
                        stg_q <= wpay;
                    end
                    if (commit && pnd_q) begin
                        reg_q <= stg_q;
                    end
                end
            end

            assign regs_w[i] = reg_q;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < NREGS) begin
            rd_data = regs_w[rd_addr[IW-1:0]];
        end
    end

    // R5
    regs_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !commit |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data)));
endmodule

// File: rtl/lc_fsm.sv
module lc_fsm
    import rlc_pkg::*;
#(
    parameter int FMT_DLY = 10
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       host_rst_n,
    input  logic       xfer_req,
    input  logic       line_start,
    input  logic       word_valid,
    input  logic       word_last,
    input  logic       csum_ok,
    input  logic       wd_expire,
    output logic       in_load,
    output logic       start,
    output logic       accept,
    output logic       commit,
    output logic       stat_valid,
    output logic [1:0] stat_code,
    output logic       run_ok,
    output logic       fmt_valid
);
    localparam int FCW = $clog2(FMT_DLY + 1);

    rlc_state_e     state_q, state_d;
    logic           host_q, h_edge, ld_act;
    logic           done_ok, bad_sum, tmo, fault;
    logic           loaded_q, used_q;
    logic [FCW-1:0] fcnt_q;

    assign h_edge  = host_q & ~host_rst_n;
    assign ld_act  = (state_q == ST_LOAD) && !h_edge;
    assign done_ok = ld_act && word_valid && word_last && csum_ok;
    assign bad_sum = ld_act && word_valid && word_last && !csum_ok;
    assign tmo     = ld_act && wd_expire && !(word_valid && word_last);
    assign fault   = bad_sum || tmo;

    always_comb begin
        state_d = state_q;
        if (h_edge) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_ARMED: if (xfer_req) state_d = ST_LOAD;
                ST_RUN:   if (xfer_req && !used_q) state_d = ST_LOAD;
                ST_LOAD: begin
                    if (done_ok)    state_d = ST_RUN;
                    else if (fault) state_d = ST_LOCK;
                end
                ST_LOCK:  state_d = ST_LOCK;
                default:  state_d = ST_LOCK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= ST_LOCK;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            host_q     <= 1'b1;
            stat_valid <= 1'b0;
            stat_code  <= SC_NONE;
            loaded_q   <= 1'b0;
            used_q     <= 1'b0;
            fcnt_q     <= '0;
        end else begin
            host_q     <= host_rst_n;
            stat_valid <= done_ok || fault;
            if (done_ok)      stat_code <= SC_DONE;
            else if (bad_sum) stat_code <= SC_SHUTDOWN;
            else if (tmo)     stat_code <= SC_OVERFLOW;
            else              stat_code <= SC_NONE;

            if (h_edge || fault) loaded_q <= 1'b0;
            else if (done_ok)    loaded_q <= 1'b1;

            if (h_edge)          used_q <= 1'b0;
            else if (done_ok)    used_q <= 1'b1;
            else if (line_start) used_q <= 1'b0;

            if (done_ok && !loaded_q) fcnt_q <= FCW'(FMT_DLY);
            else if (fcnt_q != '0)    fcnt_q <= fcnt_q - 1'b1;
        end
    end

    assign in_load   = (state_q == ST_LOAD);
    assign start     = (state_d == ST_LOAD) && (state_q != ST_LOAD);
    assign accept    = ld_act && word_valid && !word_last;
    assign commit    = done_ok;
    assign run_ok    = loaded_q;
    assign fmt_valid = loaded_q && (fcnt_q == '0);

    // R4
    stat_after_load_chk: assert property (@(posedge clk) disable iff (!arst_n)
        stat_valid |-> ($past(state_q) == ST_LOAD));
    // R5
    fault_drops_run_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (stat_valid && stat_code != SC_DONE) |-> !run_ok);
    // R7
    fmt_needs_run_chk: assert property (@(posedge clk) disable iff (!arst_n)
        fmt_valid |-> run_ok);
    // R8
    line_once_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_RUN && used_q) |=> (state_q != ST_LOAD));
endmodule

// File: rtl/reg_load_ctrl.sv
module reg_load_ctrl #(
    parameter int NREGS    = 16,
    parameter int WDOG_CYC = 256,
    parameter int FMT_DLY  = 10
) (
    input  logic        clk,
    input  logic        arst_n,
    input  logic        host_rst_n,
    input  logic        xfer_req,
    output logic        xfer_gnt,
    input  logic        line_start,
    input  logic        word_valid,
    input  logic [31:0] word_data,
    input  logic        word_last,
    output logic        stat_valid,
    output logic [1:0]  stat_code,
    output logic        run_ok,
    output logic        fmt_valid,
    input  logic [7:0]  rd_addr,
    output logic [23:0] rd_data
);
    localparam int AW = 8;
    localparam int DW = 24;

    logic start, accept, commit, csum_ok, wd_expire, in_load;

    lc_fsm #(.FMT_DLY(FMT_DLY)) u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .host_rst_n (host_rst_n),
        .xfer_req   (xfer_req),
        .line_start (line_start),
        .word_valid (word_valid),
        .word_last  (word_last),
        .csum_ok    (csum_ok),
        .wd_expire  (wd_expire),
        .in_load    (in_load),
        .start      (start),
        .accept     (accept),
        .commit     (commit),
        .stat_valid (stat_valid),
        .stat_code  (stat_code),
        .run_ok     (run_ok),
        .fmt_valid  (fmt_valid)
    );

    lc_wdog #(.LIMIT(WDOG_CYC)) u_wdog (
        .clk    (clk),
        .arst_n (arst_n),
        .active (in_load),
        .expire (wd_expire)
    );

    lc_stage #(.NREGS(NREGS), .AW(AW), .DW(DW)) u_stage (
        .clk     (clk),
        .arst_n  (arst_n),
        .start   (start),
        .accept  (accept),
        .word    (word_data),
        .commit  (commit),
        .csum_ok (csum_ok),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign xfer_gnt = in_load;

    // R2
    gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(xfer_gnt) |-> $past(xfer_req));
endmodule

// File: tb/sim_reg_load_ctrl.sv
module sim_reg_load_ctrl;
    logic        clk = 1'b0;
    logic        arst_n = 1'b0, host_rst_n = 1'b1, xfer_req = 1'b0, line_start = 1'b0;
    logic        word_valid = 1'b0, word_last = 1'b0;
    logic [31:0] word_data = '0;
    logic [7:0]  rd_addr = '0;
    logic        xfer_gnt, stat_valid, run_ok, fmt_valid;
    logic [1:0]  stat_code;
    logic [23:0] rd_data;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    reg_load_ctrl u0 (
        .clk(clk), .arst_n(arst_n), .host_rst_n(host_rst_n), .xfer_req(xfer_req),
        .xfer_gnt(xfer_gnt), .line_start(line_start), .word_valid(word_valid),
        .word_data(word_data), .word_last(word_last), .stat_valid(stat_valid),
        .stat_code(stat_code), .run_ok(run_ok), .fmt_valid(fmt_valid),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 armed, 1 load, 2 run, 3 lock
    int          m_st = 3, m_cnt = 0, m_fmt = 0, m_sc = 0;
    bit          m_loaded = 0, m_used = 0, m_hprev = 1, m_sv = 0;
    logic [31:0] m_xor = '0;
    logic [23:0] m_regs [16];
    logic [23:0] m_stg [16];
    bit          m_pnd [16];

    always @(posedge clk) begin
        bit e, fin;
        if (!arst_n) begin
            m_st = 3; m_cnt = 0; m_fmt = 0; m_sc = 0; m_sv = 0;
            m_loaded = 0; m_used = 0; m_hprev = 1; m_xor = '0;
            for (int i = 0; i < 16; i++) begin m_regs[i] = '0; m_stg[i] = '0; m_pnd[i] = 0; end
        end else begin
            e = m_hprev && !host_rst_n;
            m_hprev = host_rst_n;
            m_sv = 0; m_sc = 0; fin = 0;
            if (m_fmt > 0) m_fmt--;
            if (e) begin
                m_st = 0; m_loaded = 0; m_used = 0;
            end else begin
                if ((m_st == 0 && xfer_req) || (m_st == 2 && xfer_req && !m_used)) begin
                    m_st = 1; m_cnt = 0; m_xor = '0;
                    for (int i = 0; i < 16; i++) m_pnd[i] = 0;
                end else if (m_st == 1) begin
                    if (word_valid && word_last) begin
                        if (word_data == m_xor) begin
                            for (int i = 0; i < 16; i++) if (m_pnd[i]) m_regs[i] = m_stg[i];
                            m_sv = 1; m_sc = 3; m_st = 2; fin = 1;
                            if (!m_loaded) m_fmt = 10;
                            m_loaded = 1;
                        end else begin
                            m_sv = 1; m_sc = 2; m_st = 3; m_loaded = 0;
                        end
                    end else begin
                        if (word_valid) begin
                            m_xor = m_xor ^ word_data;
                            if (word_data[31:24] < 16) begin
                                m_stg[word_data[27:24]] = word_data[23:0];
                                m_pnd[word_data[27:24]] = 1;
                            end
                        end
                        if (m_cnt == 255) begin
                            m_sv = 1; m_sc = 1; m_st = 3; m_loaded = 0;
                        end else m_cnt++;
                    end
                end
                if (fin) m_used = 1;
                else if (line_start) m_used = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (arst_n) begin
            check("R2 grant vs model", xfer_gnt, (m_st == 1));
            check("R4 run_ok vs model", run_ok, m_loaded);
            check("R7 fmt_valid vs model", fmt_valid, (m_loaded && m_fmt == 0));
            check("R6 stat_valid vs model", stat_valid, m_sv);
            check("R5 stat_code vs model", stat_code, m_sc);
            check("R10 rd_data vs model", rd_data, (rd_addr < 16) ? m_regs[rd_addr[3:0]] : 24'h0);
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic host_toggle();
        host_rst_n = 1'b0; step(2); host_rst_n = 1'b1; step(1);
    endtask

    task automatic send(logic [31:0] w, logic last);
        word_valid = 1'b1; word_data = w; word_last = last;
        step(1);
        word_valid = 1'b0; word_last = 1'b0; word_data = '0;
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [23:0] exp);
        rd_addr = a; #1;
        check(tag, rd_data, exp);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] w1, w2, w3, w4;
        w1 = 32'h00_00AAAA; w2 = 32'h03_BBBBBB; w3 = 32'h00_CCCCCC; w4 = 32'hC8_DDDDDD;
        step(3); arst_n = 1'b1; step(1);
        // R1: lockout after power-up
        check("R1 gnt after reset", xfer_gnt, 0);
        check("R1 run_ok after reset", run_ok, 0);
        check("R1 fmt_valid after reset", fmt_valid, 0);
        rd_chk("R1 reg0 after reset", 8'd0, 24'h0);
        xfer_req = 1'b1; step(5);
        check("R1 request ignored in lock", xfer_gnt, 0);
        xfer_req = 1'b0;
        host_toggle();
        check("R2 no grant without request", xfer_gnt, 0);
        send(32'h00_123456, 1'b0); // R3: outside grant
        xfer_req = 1'b1; step(1); xfer_req = 1'b0;
        check("R2 grant after request", xfer_gnt, 1);
        send(w1, 0); send(w2, 0); send(w3, 0); send(w4, 0);
        check("R3 grant held during words", xfer_gnt, 1);
        rd_chk("R4 no commit before checksum", 8'd0, 24'h0);
        send(w1 ^ w2 ^ w3 ^ w4, 1'b1);
        check("R4 done status valid", stat_valid, 1);
        check("R4 done status code", stat_code, 2'b11);
        check("R4 run_ok after load", run_ok, 1);
        check("R4 grant dropped", xfer_gnt, 0);
        rd_chk("R4 later write wins", 8'd0, 24'hCCCCCC);
        rd_chk("R3 payload at addr 3", 8'd3, 24'hBBBBBB);
        rd_chk("R10 out of range reads 0", 8'd200, 24'h0);
        rd_addr = 8'd0;
        step(9);
        check("R7 fmt_valid low at 9", fmt_valid, 0);
        step(1);
        check("R7 fmt_valid high at 10", fmt_valid, 1);
        // R8: one transfer per line
        xfer_req = 1'b1; step(3);
        check("R8 request ignored before line start", xfer_gnt, 0);
        line_start = 1'b1; step(1); line_start = 1'b0;
        step(1);
        check("R8 grant after line start", xfer_gnt, 1);
        xfer_req = 1'b0;
        // R5: bad checksum
        send(32'h01_111111, 0); send(32'h0, 1'b1);
        check("R5 shutdown valid", stat_valid, 1);
        check("R5 shutdown code", stat_code, 2'b10);
        check("R5 run_ok dropped", run_ok, 0);
        check("R5 fmt_valid dropped", fmt_valid, 0);
        rd_chk("R5 no write on mismatch", 8'd1, 24'h0);
        rd_chk("R5 old value kept", 8'd0, 24'hCCCCCC);
        xfer_req = 1'b1; line_start = 1'b1; step(3); line_start = 1'b0;
        check("R5 request ignored in lock", xfer_gnt, 0);
        xfer_req = 1'b0;
        // R9: abort by host reset edge
        host_toggle();
        xfer_req = 1'b1; step(1); xfer_req = 1'b0;
        check("R9 grant before abort", xfer_gnt, 1);
        send(32'h02_222222, 0);
        host_rst_n = 1'b0; step(1);
        check("R9 grant ends on edge", xfer_gnt, 0);
        check("R9 no status on abort", stat_valid, 0);
        host_rst_n = 1'b1; step(1);
        rd_chk("R9 staged write discarded", 8'd2, 24'h0);
        rd_chk("R9 committed kept", 8'd0, 24'hCCCCCC);
        xfer_req = 1'b1; step(1); xfer_req = 1'b0;
        send(32'h05_0000FF, 0); send(32'h05_0000FF, 1'b1);
        check("R4 load after abort code", stat_code, 2'b11);
        rd_chk("R4 load after abort data", 8'd5, 24'h0000FF);
        // R6: watchdog
        line_start = 1'b1; step(1); line_start = 1'b0;
        xfer_req = 1'b1; step(1); xfer_req = 1'b0;
        check("R6 grant at start", xfer_gnt, 1);
        step(255);
        check("R6 grant at last allowed cycle", xfer_gnt, 1);
        step(1);
        check("R6 grant ended", xfer_gnt, 0);
        check("R6 overflow valid", stat_valid, 1);
        check("R6 overflow code", stat_code, 2'b01);
        check("R6 run_ok dropped", run_ok, 0);
        xfer_req = 1'b1; step(2);
        check("R6 request ignored after overflow", xfer_gnt, 0);
        xfer_req = 1'b0;
        step(2);
        summary();
        $finish;
    end
endmodule